// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Channel

This block is one programmable timer channel on a simple word-addressed register bus. Software sets a reload value, picks a counter size, a tick divide ratio and an operating mode, and then enables it. While enabled, the channel decrements its count once per divided tick. When a decrement step arrives with the count already at zero, the channel sets a raw interrupt flag and either reloads or stops, depending on the mode.

Three modes are provided. In free-running mode the count wraps to the all-ones value of the selected size and the load value is not used. In periodic mode the count reloads from the load value. In one-shot mode the count stays at zero after the first expiry. Two load registers share one stored value. The primary register also forces the running count. The background register changes only what the next reload will use. The interrupt output is the raw flag gated by an enable bit.

Top module: `dntimer_top`

## Requirements
- R1: After reset the control register reads 0x20 (only interrupt enable set, counting stopped), the count reads 0, the raw flag reads 0 and `irq_o` is low.
- R2: Register word offsets: 2 control, 0 load, 6 background load, 1 count (read only), 3 interrupt clear, 4 raw status, 5 masked status. Control bits: bit 7 run, bit 6 periodic, bit 5 interrupt enable, bits 3:2 divide select, bit 1 wide (32-bit, clear = 16-bit), bit 0 one-shot. The count never changes while bit 7 is clear.
- R3: A control write with bit 7 set reloads the count at once, with the reload value chosen by the newly written control. Every control write restarts the tick divider from zero.
- R4: Divide select 0 steps the count on every tick, 1 on every 16th tick and 2 on every 256th tick. Code 3 acts as 0.
- R5: A write to offset 0 stores the load value and sets the count to it on the next cycle, masked to 16 bits when bit 1 is clear.
- R6: A write to offset 6 stores the load value but leaves the running count unchanged. Offsets 0 and 6 read back the same stored value.
- R7: In periodic mode (bit 6 set, bit 0 clear), a step that finds the count at zero sets the raw flag and reloads the count from the load value.
- R8: When bits 6 and 0 are both clear, a step at zero sets the raw flag and reloads 0xFFFF (16-bit) or 0xFFFFFFFF (32-bit), whatever the load value.
- R9: In one-shot mode (bit 0 set), the first step at zero sets the raw flag, and the count then stays at zero with no further expiry until the next load or control write.
- R10: `irq_o` is high exactly when the raw flag and interrupt enable are both set. Offset 4 reads the raw flag in bit 0. Offset 5 reads the raw flag gated by interrupt enable, so it reads 0 whenever enable is clear.
- R11: Any write to offset 3 clears the raw flag. If an expiry happens in the same cycle, the flag stays set.
- R12: Writes to offset 1 leave the count unchanged. Offset 7 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Count tick enable, one per cycle at most |
| bus_wr_i | input | 1 | Write strobe for the addressed register |
| bus_addr_i | input | ADDR_W | Word offset of the register |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Gated interrupt request |

## Verification
A wrong count or a wrong divider phase shows up at offset 1 one cycle after the faulty step. The bench therefore reads the count after each exact burst of ticks, and a single lost or extra step becomes a value mismatch. A missing reload or a one-shot that fails to stop appears at the count read right after the expiry tick. A bad flag or gating fault appears on `irq_o` and on offsets 4 and 5 in that same cycle. A divider that does not restart on a control write leaves the count one step ahead after a burst shorter than the ratio.

// File: rtl/dntimer_pkg.sv
// Package: shared offsets, control bit positions and divide codes for the
// down-counting timer channel. Assumes word addressing on a 3-bit offset.
package dntimer_pkg;
    localparam int CTRL_W = 8;

    localparam logic [2:0] OFS_LOAD  = 3'd0;
    localparam logic [2:0] OFS_COUNT = 3'd1;
    localparam logic [2:0] OFS_CTRL  = 3'd2;
    localparam logic [2:0] OFS_CLR   = 3'd3;
    localparam logic [2:0] OFS_RAW   = 3'd4;
    localparam logic [2:0] OFS_MASK  = 3'd5;
    localparam logic [2:0] OFS_BGLD  = 3'd6;

    localparam int B_ONESHOT = 0;
    localparam int B_WIDE    = 1;
    localparam int B_DIV_LO  = 2;
    localparam int B_IE      = 5;
    localparam int B_PERIOD  = 6;
    localparam int B_RUN     = 7;

    localparam logic [CTRL_W-1:0] CTRL_RST = 8'h20;

    typedef enum logic [1:0] {
        DIV_1   = 2'd0,
        DIV_16  = 2'd1,
        DIV_256 = 2'd2,
        DIV_RSV = 2'd3
    } div_sel_e;
endpackage

// File: rtl/dntimer_prescale.sv
// Tick divider: emits one step per 1, 16 or 256 qualified ticks.
// Assumes PS_W is at least 8 and that the restart input lasts one cycle.
module dntimer_prescale
    import dntimer_pkg::*;
#(
    parameter int PS_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] div_sel,
    output logic       step
);
    logic [PS_W-1:0] pcnt;
    logic [PS_W-1:0] lim;

    // Terminal value of the divider for the selected ratio.
    always_comb begin
        unique case (div_sel_e'(div_sel))
            DIV_16:  lim = PS_W'(15);
            DIV_256: lim = PS_W'(255);
            default: lim = '0;
        endcase
    end

    // Divider phase counter; returns to zero on restart or terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pcnt <= '0;
        end else if (tick && run) begin
            pcnt <= (pcnt == lim) ? '0 : pcnt + PS_W'(1);
        end
    end

    assign step = tick && run && (pcnt == lim);
endmodule

// File: rtl/dntimer_count.sv
// Down counter with mode-dependent reload and one-shot halt.
// Assumes ld_force and ctrl_wr never occur together (distinct offsets).
// A forced load or control write takes priority over a step in that cycle.
module dntimer_count
    import dntimer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             ld_force,
    input  logic             ctrl_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] load_q,
    input  logic             wide,
    input  logic             periodic,
    input  logic             oneshot,
    output logic [CNT_W-1:0] count,
    output logic             expire,
    output logic             halted
);
    localparam int HALF = CNT_W / 2;

    logic [CNT_W-1:0] cur_mask;
    logic [CNT_W-1:0] cur_reload;
    logic [CNT_W-1:0] new_mask;
    logic [CNT_W-1:0] new_reload;
    logic             new_run;

    // Width masks and reload values for current and newly written control.
    always_comb begin
        cur_mask   = wide ? '1 : {{(CNT_W-HALF){1'b0}}, {HALF{1'b1}}};
        cur_reload = (periodic || oneshot) ? (load_q & cur_mask) : cur_mask;
        new_mask   = wdata[B_WIDE] ? '1 : {{(CNT_W-HALF){1'b0}}, {HALF{1'b1}}};
        new_reload = (wdata[B_PERIOD] || wdata[B_ONESHOT]) ? (load_q & new_mask)
                                                           : new_mask;
        new_run    = wdata[B_RUN];
    end

    assign expire = step && !halted && (count == '0) && !ld_force && !ctrl_wr;

    // Count register: forced load, start reload, expiry reload or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            halted <= 1'b0;
        end else if (ld_force) begin
            count  <= wdata & cur_mask;
            halted <= 1'b0;
        end else if (ctrl_wr) begin
            halted <= 1'b0;
            if (new_run) count <= new_reload;
        end else if (expire) begin
            if (oneshot) halted <= 1'b1;
            else         count  <= cur_reload;
        end else if (step && !halted) begin
            count <= count - CNT_W'(1);
        end
    end
endmodule

// File: rtl/dntimer_regs.sv
// Register file and read mux: control, stored load value, raw flag.
// Assumes a single-cycle write strobe; reads are combinational.
module dntimer_regs
    import dntimer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              expire,
    output logic [CTRL_W-1:0] ctrl,
    output logic [CNT_W-1:0]  load_q,
    output logic              raw,
    output logic              ld_force,
    output logic              ctrl_wr,
    output logic [CNT_W-1:0]  rdata
);
    logic bg_wr;
    logic clr_wr;

    // Write decode per offset.
    always_comb begin
        ld_force = wr && (addr == ADDR_W'(OFS_LOAD));
        ctrl_wr  = wr && (addr == ADDR_W'(OFS_CTRL));
        bg_wr    = wr && (addr == ADDR_W'(OFS_BGLD));
        clr_wr   = wr && (addr == ADDR_W'(OFS_CLR));
    end

    // Control and load storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= CTRL_RST;
            load_q <= '0;
        end else begin
            if (ctrl_wr)           ctrl   <= wdata[CTRL_W-1:0];
            if (ld_force || bg_wr) load_q <= wdata;
        end
    end

    // Raw interrupt flag: expiry sets, clear write resets, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)      raw <= 1'b0;
        else if (expire) raw <= 1'b1;
        else if (clr_wr) raw <= 1'b0;
    end

    // Read mux; unmapped offsets read zero.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_LOAD) || addr == ADDR_W'(OFS_BGLD)) rdata = load_q;
        else if (addr == ADDR_W'(OFS_COUNT)) rdata = count;
        else if (addr == ADDR_W'(OFS_CTRL))  rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl};
        else if (addr == ADDR_W'(OFS_RAW))   rdata = {{(CNT_W-1){1'b0}}, raw};
        else if (addr == ADDR_W'(OFS_MASK))  rdata = {{(CNT_W-1){1'b0}}, raw && ctrl[B_IE]};
    end
endmodule

// File: rtl/dntimer_top.sv
// Timer channel top: ties register file, tick divider and counter together.
// Assumes tick_i is synchronous to clk; the interrupt output is combinational.
module dntimer_top
    import dntimer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 3,
    parameter int PS_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [CNT_W-1:0]  bus_wdata_i,
    output logic [CNT_W-1:0]  bus_rdata_o,
    output logic              irq_o
);
    logic [CTRL_W-1:0] ctrl;
    logic [CNT_W-1:0]  load_q;
    logic [CNT_W-1:0]  count;
    logic              raw;
    logic              ld_force;
    logic              ctrl_wr;
    logic              step;
    logic              expire;
    logic              halted;

    dntimer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr_i),
        .addr     (bus_addr_i),
        .wdata    (bus_wdata_i),
        .count    (count),
        .expire   (expire),
        .ctrl     (ctrl),
        .load_q   (load_q),
        .raw      (raw),
        .ld_force (ld_force),
        .ctrl_wr  (ctrl_wr),
        .rdata    (bus_rdata_o)
    );

    dntimer_prescale #(.PS_W(PS_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_i),
        .run     (ctrl[B_RUN]),
        .restart (ctrl_wr),
        .div_sel (ctrl[B_DIV_LO+1:B_DIV_LO]),
        .step    (step)
    );

    dntimer_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .ld_force (ld_force),
        .ctrl_wr  (ctrl_wr),
        .wdata    (bus_wdata_i),
        .load_q   (load_q),
        .wide     (ctrl[B_WIDE]),
        .periodic (ctrl[B_PERIOD]),
        .oneshot  (ctrl[B_ONESHOT]),
        .count    (count),
        .expire   (expire),
        .halted   (halted)
    );

    // Interrupt output: raw flag gated by enable.
    assign irq_o = raw && ctrl[B_IE];
endmodule

// File: rtl/dntimer_chk.sv
// Checker for the timer channel, bound into dntimer_top.
// Assumes synchronous active-low reset; all properties are single-cycle.
module dntimer_chk
    import dntimer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  wdata,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  load_q,
    input logic [CTRL_W-1:0] ctrl,
    input logic              raw,
    input logic              expire,
    input logic              halted,
    input logic              step,
    input logic              irq
);
    localparam int HALF = CNT_W / 2;

    // R12: a write to the count offset does not move a stopped count.
    assert_cnt_wr_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_W'(OFS_COUNT) && !step) |=> $stable(count));

    // R12: writes to the unmapped offset change no stored register.
    assert_unmapped_wr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_W'(7)) |=> ($stable(load_q) && $stable(ctrl)));

    // R11: a clear write without an expiry drops the raw flag.
    assert_clear_drops_raw_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_W'(OFS_CLR) && !expire) |=> !raw);

    // R11: an expiry always leaves the raw flag set.
    assert_expire_sets_raw_R11: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> raw);

    // R5: a load write forces the count to the masked written value.
    assert_load_forces_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_W'(OFS_LOAD)) |=>
        (count == ($past(ctrl[B_WIDE]) ? $past(wdata)
                  : {{(CNT_W-HALF){1'b0}}, $past(wdata[HALF-1:0])})));

    // R6: a background load write with no step leaves the count alone.
    assert_bg_load_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_W'(OFS_BGLD) && !step) |=> $stable(count));

    // R9: a halted one-shot keeps its zero count until rewritten.
    assert_oneshot_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !wr) |=> (count == '0 && !expire));

    // R2: the count holds while the run bit is clear and nothing writes.
    assert_stopped_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[B_RUN] && !wr) |=> $stable(count));

    // R10: interrupt output never high without the raw flag.
    assert_irq_needs_raw_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw && ctrl[B_IE]));
endmodule

bind dntimer_top dntimer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (bus_wr_i),
    .addr   (bus_addr_i),
    .wdata  (bus_wdata_i),
    .count  (count),
    .load_q (load_q),
    .ctrl   (ctrl),
    .raw    (raw),
    .expire (expire),
    .halted (halted),
    .step   (step),
    .irq    (irq_o)
);

// File: tb/dntimer_top_tb.sv
// Scoreboard bench: driver tasks queue expected values, a monitor compares.
module dntimer_top_tb;
    localparam int CNT_W  = 32;
    localparam int ADDR_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              wr = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [CNT_W-1:0]  wdata = '0;
    logic [CNT_W-1:0]  rdata;
    logic              irq;

    typedef struct {
        logic [CNT_W-1:0] exp;
        int               req;
        bit               is_irq;
    } item_t;

    item_t sb_q[$];
    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dntimer_top #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    // Monitor: pop and compare on the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [CNT_W-1:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {{(CNT_W-1){1'b0}}, irq} : rdata;
                n_vec++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL R%0d addr=%0d actual=%h expected=%h",
                             it.req, addr, act, it.exp);
                end
            end
        end
    end

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] d);
        @(posedge clk); #1;
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic expect_rd(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] e,
                             input int req);
        item_t it;
        @(posedge clk); #1;
        addr = a;
        it.exp = e; it.req = req; it.is_irq = 1'b0;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic expect_irq(input logic e, input int req);
        item_t it;
        @(posedge clk); #1;
        it.exp = {{(CNT_W-1){1'b0}}, e}; it.req = req; it.is_irq = 1'b1;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic ticks(input int n);
        @(posedge clk); #1;
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        expect_rd(3'd2, 32'h20, 1);
        expect_rd(3'd1, 32'h0, 1);
        expect_rd(3'd4, 32'h0, 1);
        expect_irq(1'b0, 1);

        // R5: load write forces count while stopped
        bus_wr(3'd0, 32'd10);
        expect_rd(3'd1, 32'd10, 5);

        // R3, R2: start periodic 32-bit with interrupts, count reloads
        bus_wr(3'd2, 32'hE2);
        expect_rd(3'd1, 32'd10, 3);
        ticks(3);
        expect_rd(3'd1, 32'd7, 2);

        // R6: background load leaves count, both offsets read it
        bus_wr(3'd6, 32'd5);
        expect_rd(3'd1, 32'd7, 6);
        expect_rd(3'd6, 32'd5, 6);
        expect_rd(3'd0, 32'd5, 6);

        // R7: count to zero, then expiry reloads from load
        ticks(7);
        expect_rd(3'd1, 32'd0, 7);
        expect_rd(3'd4, 32'd0, 7);
        ticks(1);
        expect_rd(3'd1, 32'd5, 7);
        expect_rd(3'd4, 32'd1, 7);
        expect_rd(3'd5, 32'd1, 10);   // R10
        expect_irq(1'b1, 10);

        // R12: count write ignored
        bus_wr(3'd1, 32'd99);
        expect_rd(3'd1, 32'd5, 12);

        // R11: clear write drops raw flag and irq
        bus_wr(3'd3, 32'h0);
        expect_rd(3'd4, 32'd0, 11);
        expect_irq(1'b0, 11);

        // R10: interrupt enable clear masks output and masked status
        bus_wr(3'd2, 32'hC2);
        ticks(6);
        expect_rd(3'd4, 32'd1, 10);
        expect_rd(3'd5, 32'd0, 10);
        expect_irq(1'b0, 10);
        bus_wr(3'd3, 32'h0);

        // R9: one-shot expires once and holds at zero
        bus_wr(3'd2, 32'hA3);
        ticks(6);
        expect_rd(3'd4, 32'd1, 9);
        expect_rd(3'd1, 32'd0, 9);
        ticks(10);
        expect_rd(3'd1, 32'd0, 9);
        bus_wr(3'd3, 32'h0);
        ticks(4);
        expect_rd(3'd4, 32'd0, 9);

        // R8: free-running 16-bit wraps at 0xFFFF ignoring load
        bus_wr(3'd2, 32'hA0);
        expect_rd(3'd1, 32'h0000FFFF, 8);
        ticks(2);
        expect_rd(3'd1, 32'h0000FFFD, 8);
        bus_wr(3'd0, 32'd3);
        ticks(4);
        expect_rd(3'd1, 32'h0000FFFF, 8);
        expect_rd(3'd4, 32'd1, 8);
        bus_wr(3'd3, 32'h0);
        // R8: free-running 32-bit starts at all ones
        bus_wr(3'd2, 32'hA2);
        expect_rd(3'd1, 32'hFFFFFFFF, 8);

        // R4: divide by 16
        bus_wr(3'd2, 32'hE6);
        bus_wr(3'd0, 32'd100);
        ticks(32);
        expect_rd(3'd1, 32'd98, 4);
        ticks(15);
        expect_rd(3'd1, 32'd98, 4);
        ticks(1);
        expect_rd(3'd1, 32'd97, 4);
        // R4: divide by 256
        bus_wr(3'd2, 32'hEA);
        ticks(255);
        expect_rd(3'd1, 32'd100, 4);
        ticks(1);
        expect_rd(3'd1, 32'd99, 4);

        // R3: control write restarts the divider phase
        bus_wr(3'd2, 32'hE6);
        ticks(10);
        bus_wr(3'd2, 32'hE6);
        ticks(10);
        expect_rd(3'd1, 32'd100, 3);

        // R2: run bit clear stops counting, no reload on control write
        bus_wr(3'd2, 32'h22);
        ticks(5);
        expect_rd(3'd1, 32'd100, 2);

        // R12: unmapped offset reads zero, write has no effect
        expect_rd(3'd7, 32'd0, 12);
        bus_wr(3'd7, 32'h1234);
        expect_rd(3'd0, 32'd100, 12);
        expect_rd(3'd2, 32'h22, 12);

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule